// File: doc/BRIEF.md
# CPU Flag and Interrupt-Enable Unit

This block keeps three single-bit pieces of processor state for a small 4-bit microcontroller core. The first is a zero flag that follows accumulator loads. The second is an overflow flag that reports when one of the 8-bit pointer pairs wraps during an increment. The third is a master interrupt enable that gates the maskable interrupt requests.

The surrounding core drives the block with strobes and data. The instruction decoder drives the enable, disable, return-from-interrupt and exchange strobes. The register file drives the accumulator value and the pre-increment pointer values. The interrupt sources drive their raw request levels. The block returns the gated requests and a one-cycle accept pulse, which the priority encoder uses to start an interrupt entry.

The watchdog request bypasses the master enable. The master enable is also visible to data-memory reads as bit 0 of a 4-bit status register at the top address of the data space. Data-memory writes to that register have no effect.

Top module: `cpu_flag_unit`

## Requirements
- R1: An accumulator load that is not an exchange sets `zero_flag` to 1 in the cycle after the strobe when `acc_data` is 0, and clears it to 0 when `acc_data` is nonzero.
- R2: An accumulator load with `acc_load_xch` high leaves `zero_flag` unchanged.
- R3: In any cycle where at least one bit of `ptr_inc` is high, `ovf_flag` takes a new value on the next cycle. It becomes 1 if any selected pointer field of `ptr_val` (pointer k occupies bits k*8+7..k*8) holds FFH, and 0 otherwise. In a cycle with no increment strobe, `ovf_flag` keeps its value.
- R4: After synchronous reset, `zero_flag`, `ovf_flag`, `mie`, `int_take` and `rd_data` are all 0.
- R5: `irq_pass` equals `irq_req` while `mie` is 1 and is all zeros while `mie` is 0. `wdt_pass` always equals `wdt_req`.
- R6: `op_ei` or `op_rti` sets `mie` to 1 on the next cycle, and `op_di` clears it. When no interrupt is accepted, EI/RTI win over DI.
- R7: An interrupt is accepted at a clock edge when `int_take` is 0 and either `wdt_req` is high or `mie` is 1 with any bit of `irq_req` high. At that edge `int_take` becomes 1 for one cycle and `mie` becomes 0. Requests held while masked are accepted at the first edge after `mie` becomes 1.
- R8: An acceptance clears `mie` even when EI or RTI is strobed in the same cycle.
- R9: A read with `rd_en` high at address FFH returns {3'b000, mie} on `rd_data` on the next cycle, using the `mie` value at the read edge. A read at any other address, or no read, returns 0.
- R10: A write with `wr_en` high, at any address and with any data, changes neither `mie` nor the value later read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_load | input | 1 | Accumulator was loaded this cycle |
| acc_load_xch | input | 1 | The load came from the exchange instruction |
| acc_data | input | 4 | Value loaded into the accumulator |
| ptr_inc | input | 3 | Per-pointer increment strobes |
| ptr_val | input | 24 | Pre-increment pointer values, 8 bits per pointer |
| op_ei | input | 1 | Enable-interrupts strobe |
| op_di | input | 1 | Disable-interrupts strobe |
| op_rti | input | 1 | Return-from-interrupt strobe |
| irq_req | input | 4 | Maskable interrupt request levels |
| wdt_req | input | 1 | Watchdog interrupt request |
| rd_en | input | 1 | Data-memory read strobe |
| rd_addr | input | 8 | Data-memory read address |
| wr_en | input | 1 | Data-memory write strobe |
| wr_addr | input | 8 | Data-memory write address |
| wr_data | input | 4 | Data-memory write data |
| zero_flag | output | 1 | Zero flag |
| ovf_flag | output | 1 | Pointer-overflow flag |
| mie | output | 1 | Master interrupt enable |
| irq_pass | output | 4 | Maskable requests after gating |
| wdt_pass | output | 1 | Watchdog request, never gated |
| int_take | output | 1 | One-cycle interrupt accept pulse |
| rd_data | output | 4 | Status register read data |

## Verification
Interrupt acceptance and an EI or RTI strobe can both land on the same clock edge, and each wants to move the master enable in the opposite direction. The bench first sets the enable, then raises a maskable request in the same cycle as EI, and separately in the same cycle as RTI. It passes only when the accept pulse appears and the enable reads back as 0.

A second pair also meets on one edge: a status read and an enable change. The bench reads the status register in the same cycle as EI, DI or an acceptance, and expects the value that the enable held before that edge.

// File: rtl/flag_pkg.sv
package flag_pkg;
  // Next-state command for the master enable, resolved by priority.
  typedef enum logic [1:0] {
    MIE_HOLD = 2'd0,
    MIE_SET  = 2'd1,
    MIE_CLR  = 2'd2
  } mie_cmd_e;

  function automatic mie_cmd_e mie_resolve(input logic take,
                                           input logic set_req,
                                           input logic clr_req);
    if (take)         return MIE_CLR;
    else if (set_req) return MIE_SET;
    else if (clr_req) return MIE_CLR;
    else              return MIE_HOLD;
  endfunction
endpackage

// File: rtl/zflag_unit.sv
module zflag_unit #(
  parameter int ACC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             load_xch,
  input  logic [ACC_W-1:0] data,
  output logic             zf
);
  logic upd;
  assign upd = load & ~load_xch;

  always_ff @(posedge clk) begin
    if (rst)      zf <= 1'b0;
    else if (upd) zf <= (data == '0);
  end
endmodule

// File: rtl/gflag_unit.sv
module gflag_unit #(
  parameter int PTR_W = 8,
  parameter int NPTR  = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NPTR-1:0]       inc,
  input  logic [NPTR*PTR_W-1:0] val,
  output logic                  gf
);
  logic [NPTR-1:0] wrap;

  for (genvar k = 0; k < NPTR; k++) begin : g_ptr
    assign wrap[k] = inc[k] & (&val[k*PTR_W +: PTR_W]);
  end

  always_ff @(posedge clk) begin
    if (rst)       gf <= 1'b0;
    else if (|inc) gf <= |wrap;
  end
endmodule

// File: rtl/mie_unit.sv
module mie_unit
  import flag_pkg::*;
#(
  parameter int NIRQ = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ei,
  input  logic            di,
  input  logic            rti,
  input  logic [NIRQ-1:0] irq,
  input  logic            wdt,
  output logic            mie_q,
  output logic            take_q,
  output logic [NIRQ-1:0] gated
);
  logic     cand;
  logic     take_now;
  mie_cmd_e cmd;

  assign gated    = irq & {NIRQ{mie_q}};
  assign cand     = (|gated) | wdt;
  assign take_now = cand & ~take_q;
  assign cmd      = mie_resolve(take_now, ei | rti, di);

  always_ff @(posedge clk) begin
    if (rst) begin
      mie_q  <= 1'b0;
      take_q <= 1'b0;
    end else begin
      take_q <= take_now;
      case (cmd)
        MIE_SET: mie_q <= 1'b1;
        MIE_CLR: mie_q <= 1'b0;
        default: mie_q <= mie_q;
      endcase
    end
  end
endmodule

// File: rtl/cpu_flag_unit.sv
module cpu_flag_unit #(
  parameter int                ACC_W     = 4,
  parameter int                PTR_W     = 8,
  parameter int                NPTR      = 3,
  parameter int                NIRQ      = 4,
  parameter int                REG_W     = 4,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = '1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  acc_load,
  input  logic                  acc_load_xch,
  input  logic [ACC_W-1:0]      acc_data,
  input  logic [NPTR-1:0]       ptr_inc,
  input  logic [NPTR*PTR_W-1:0] ptr_val,
  input  logic                  op_ei,
  input  logic                  op_di,
  input  logic                  op_rti,
  input  logic [NIRQ-1:0]       irq_req,
  input  logic                  wdt_req,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     rd_addr,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [REG_W-1:0]      wr_data,
  output logic                  zero_flag,
  output logic                  ovf_flag,
  output logic                  mie,
  output logic [NIRQ-1:0]       irq_pass,
  output logic                  wdt_pass,
  output logic                  int_take,
  output logic [REG_W-1:0]      rd_data
);
  logic stat_hit;
  logic unused_wr;

  // The status register is read-only: the write port is sunk here.
  assign unused_wr = ^{wr_en, wr_addr, wr_data};

  zflag_unit #(.ACC_W(ACC_W)) u_z (
    .clk(clk), .rst(rst), .load(acc_load), .load_xch(acc_load_xch),
    .data(acc_data), .zf(zero_flag)
  );

  gflag_unit #(.PTR_W(PTR_W), .NPTR(NPTR)) u_g (
    .clk(clk), .rst(rst), .inc(ptr_inc), .val(ptr_val), .gf(ovf_flag)
  );

  mie_unit #(.NIRQ(NIRQ)) u_m (
    .clk(clk), .rst(rst), .ei(op_ei), .di(op_di), .rti(op_rti),
    .irq(irq_req), .wdt(wdt_req), .mie_q(mie), .take_q(int_take),
    .gated(irq_pass)
  );

  assign wdt_pass = wdt_req;
  assign stat_hit = rd_en & (rd_addr == STAT_ADDR);

  always_ff @(posedge clk) begin
    if (rst)           rd_data <= '0;
    else if (stat_hit) rd_data <= REG_W'(mie);
    else               rd_data <= '0;
  end
endmodule

// File: rtl/cpu_flag_unit_chk.sv
module cpu_flag_unit_chk #(
  parameter int                ACC_W     = 4,
  parameter int                PTR_W     = 8,
  parameter int                NPTR      = 3,
  parameter int                NIRQ      = 4,
  parameter int                REG_W     = 4,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = '1
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  acc_load,
  input logic                  acc_load_xch,
  input logic [ACC_W-1:0]      acc_data,
  input logic [NPTR-1:0]       ptr_inc,
  input logic [NPTR*PTR_W-1:0] ptr_val,
  input logic                  op_ei,
  input logic                  op_rti,
  input logic [NIRQ-1:0]       irq_req,
  input logic                  wdt_req,
  input logic                  rd_en,
  input logic [ADDR_W-1:0]     rd_addr,
  input logic                  zero_flag,
  input logic                  ovf_flag,
  input logic                  mie,
  input logic [NIRQ-1:0]       irq_pass,
  input logic                  wdt_pass,
  input logic                  int_take,
  input logic [REG_W-1:0]      rd_data
);
  p_zero_set_r1: assert property (@(posedge clk) disable iff (rst)
    (acc_load && !acc_load_xch && acc_data == '0) |=> zero_flag);
  p_zero_clr_r1: assert property (@(posedge clk) disable iff (rst)
    (acc_load && !acc_load_xch && acc_data != '0) |=> !zero_flag);
  p_xch_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (acc_load && acc_load_xch) |=> $stable(zero_flag));
  p_wrap_sets_r3: assert property (@(posedge clk) disable iff (rst)
    (ptr_inc[0] && ptr_val[PTR_W-1:0] == '1) |=> ovf_flag);
  p_no_inc_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (ptr_inc == '0) |=> $stable(ovf_flag));
  p_gate_r5: assert property (@(posedge clk) disable iff (rst)
    !mie |-> (irq_pass == '0));
  p_wdt_bypass_r5: assert property (@(posedge clk) disable iff (rst)
    wdt_pass == wdt_req);
  p_take_clears_r7: assert property (@(posedge clk) disable iff (rst)
    int_take |-> !mie);
  p_take_single_r7: assert property (@(posedge clk) disable iff (rst)
    int_take |=> !int_take);
  p_take_beats_set_r8: assert property (@(posedge clk) disable iff (rst)
    (mie && (irq_req != '0) && !int_take && (op_ei || op_rti)) |=> (int_take && !mie));
  p_stat_upper_r9: assert property (@(posedge clk) disable iff (rst)
    rd_data[REG_W-1:1] == '0);
  p_stat_read_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == STAT_ADDR) |=> (rd_data[0] == $past(mie)));
endmodule

bind cpu_flag_unit cpu_flag_unit_chk #(
  .ACC_W(ACC_W), .PTR_W(PTR_W), .NPTR(NPTR), .NIRQ(NIRQ),
  .REG_W(REG_W), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .acc_load(acc_load), .acc_load_xch(acc_load_xch),
  .acc_data(acc_data), .ptr_inc(ptr_inc), .ptr_val(ptr_val),
  .op_ei(op_ei), .op_rti(op_rti), .irq_req(irq_req), .wdt_req(wdt_req),
  .rd_en(rd_en), .rd_addr(rd_addr), .zero_flag(zero_flag),
  .ovf_flag(ovf_flag), .mie(mie), .irq_pass(irq_pass),
  .wdt_pass(wdt_pass), .int_take(int_take), .rd_data(rd_data)
);

// File: tb/sim_cpu_flag_unit.sv
module sim_cpu_flag_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst;
  logic        acc_load, acc_load_xch;
  logic [3:0]  acc_data;
  logic [2:0]  ptr_inc;
  logic [23:0] ptr_val;
  logic        op_ei, op_di, op_rti;
  logic [3:0]  irq_req;
  logic        wdt_req;
  logic        rd_en;
  logic [7:0]  rd_addr;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [3:0]  wr_data;
  logic        zero_flag, ovf_flag, mie, wdt_pass, int_take;
  logic [3:0]  irq_pass, rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // bench model
  logic m_z, m_g, m_mie, m_take;
  logic [3:0] m_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_flag_unit u0 (
    .clk(clk), .rst(rst), .acc_load(acc_load), .acc_load_xch(acc_load_xch),
    .acc_data(acc_data), .ptr_inc(ptr_inc), .ptr_val(ptr_val),
    .op_ei(op_ei), .op_di(op_di), .op_rti(op_rti), .irq_req(irq_req),
    .wdt_req(wdt_req), .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .zero_flag(zero_flag),
    .ovf_flag(ovf_flag), .mie(mie), .irq_pass(irq_pass),
    .wdt_pass(wdt_pass), .int_take(int_take), .rd_data(rd_data)
  );

  task automatic check(input string req, input string what,
                       input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic idle();
    acc_load = 0; acc_load_xch = 0; acc_data = 0;
    ptr_inc = 0; ptr_val = 0;
    op_ei = 0; op_di = 0; op_rti = 0;
    irq_req = 0; wdt_req = 0;
    rd_en = 0; rd_addr = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
  endtask

  // One clock: compute expectations from the requirements, then compare.
  task automatic cyc();
    logic nz, ng, nm, nt, cand;
    logic [3:0] nr;
    if (rst) begin
      nz = 0; ng = 0; nm = 0; nt = 0; nr = 0;
    end else begin
      nz = (acc_load && !acc_load_xch) ? (acc_data == 4'h0) : m_z;
      ng = m_g;
      if (ptr_inc != 0) begin
        ng = 0;
        for (int k = 0; k < 3; k++)
          if (ptr_inc[k] && ptr_val[k*8 +: 8] == 8'hFF) ng = 1;
      end
      cand = wdt_req || (m_mie && irq_req != 0);
      nt = cand && !m_take;
      if (nt)                   nm = 0;
      else if (op_ei || op_rti) nm = 1;
      else if (op_di)           nm = 0;
      else                      nm = m_mie;
      nr = (rd_en && rd_addr == 8'hFF) ? {3'b000, m_mie} : 4'h0;
    end
    @(posedge clk); #1;
    m_z = nz; m_g = ng; m_mie = nm; m_take = nt; m_rd = nr;
    check(rst ? "R4" : "R1/R2", "zero_flag", {3'b0, zero_flag}, {3'b0, m_z});
    check(rst ? "R4" : "R3", "ovf_flag", {3'b0, ovf_flag}, {3'b0, m_g});
    check(rst ? "R4" : "R6/R8", "mie", {3'b0, mie}, {3'b0, m_mie});
    check(rst ? "R4" : "R7", "int_take", {3'b0, int_take}, {3'b0, m_take});
    check(rst ? "R4" : "R9/R10", "rd_data", rd_data, m_rd);
    check("R5", "irq_pass", irq_pass, irq_req & {4{m_mie}});
    check("R5", "wdt_pass", {3'b0, wdt_pass}, {3'b0, wdt_req});
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    m_z = 0; m_g = 0; m_mie = 0; m_take = 0; m_rd = 0;
    rst = 1;
    @(negedge clk);
    // R4: reset state
    cyc(); cyc();
    rst = 0;

    // R1 / R2: every accumulator value, plain load then exchange load
    for (int x = 0; x < 2; x++) begin
      for (int v = 0; v < 16; v++) begin
        idle(); acc_load = 1; acc_load_xch = x[0]; acc_data = v[3:0];
        cyc();
        idle(); acc_load = 1; acc_load_xch = x[0]; acc_data = 4'(15 - v);
        cyc();
      end
    end

    // R3: every value on every pointer, then multi-pointer and idle cycles
    for (int k = 0; k < 3; k++) begin
      for (int v = 0; v < 256; v++) begin
        idle(); ptr_inc = 3'(1 << k);
        ptr_val = {3{8'(v ^ 8'hFF)}};
        ptr_val[k*8 +: 8] = v[7:0];
        cyc();
        idle(); ptr_val = 24'hFFFFFF; cyc(); // R3: no strobe, flag held
      end
    end
    for (int p = 0; p < 8; p++) begin
      idle(); ptr_inc = p[2:0]; ptr_val = 24'h12FF34; cyc();
    end

    // R5 / R6 / R7: every request pattern with enable off and on, then drained
    for (int p = 0; p < 16; p++) begin
      for (int e = 0; e < 2; e++) begin
        idle(); if (e == 1) op_ei = 1; else op_di = 1;
        cyc();
        idle(); irq_req = p[3:0]; cyc(); cyc(); cyc();
        idle(); op_rti = 1; irq_req = p[3:0]; cyc(); cyc(); cyc();
        idle(); op_di = 1; cyc();
      end
    end

    // R7: held request while masked is taken once EI lands
    idle(); op_di = 1; cyc();
    idle(); irq_req = 4'b0100; cyc(); cyc(); cyc();
    idle(); irq_req = 4'b0100; op_ei = 1; cyc(); cyc(); cyc();

    // R5 / R7: watchdog with enable off
    idle(); op_di = 1; cyc();
    idle(); wdt_req = 1; cyc(); cyc(); cyc(); cyc();
    idle(); cyc();

    // R8: acceptance on the same edge as EI, then as RTI
    idle(); op_ei = 1; cyc();
    idle(); irq_req = 4'b0001; op_ei = 1; cyc();
    idle(); cyc();
    idle(); op_rti = 1; cyc();
    idle(); irq_req = 4'b1000; op_rti = 1; cyc();
    idle(); cyc();
    // R6: EI beats DI
    idle(); op_ei = 1; op_di = 1; cyc();

    // R9: all read addresses with enable both ways; read coinciding with changes
    for (int e = 0; e < 2; e++) begin
      idle(); if (e == 1) op_ei = 1; else op_di = 1;
      cyc();
      for (int a = 0; a < 256; a++) begin
        idle(); rd_en = 1; rd_addr = a[7:0]; cyc();
      end
      idle(); rd_addr = 8'hFF; cyc(); // R9: no strobe reads 0
    end
    idle(); rd_en = 1; rd_addr = 8'hFF; op_di = 1; cyc();
    idle(); rd_en = 1; rd_addr = 8'hFF; op_ei = 1; cyc();
    idle(); rd_en = 1; rd_addr = 8'hFF; irq_req = 4'b0010; cyc();
    idle(); rd_en = 1; rd_addr = 8'hFF; cyc();

    // R10: writes of every value to the status address and elsewhere
    for (int e = 0; e < 2; e++) begin
      idle(); if (e == 1) op_ei = 1; else op_di = 1;
      cyc();
      for (int d = 0; d < 16; d++) begin
        idle(); wr_en = 1; wr_addr = 8'hFF; wr_data = d[3:0]; cyc();
        idle(); rd_en = 1; rd_addr = 8'hFF; cyc();
        idle(); wr_en = 1; wr_addr = 8'(d * 17); wr_data = ~d[3:0]; cyc();
        idle(); rd_en = 1; rd_addr = 8'hFF; cyc();
      end
    end

    // R4: reset from a busy state
    idle(); op_ei = 1; acc_load = 1; ptr_inc = 3'b001; ptr_val = 24'h0000FF; cyc();
    idle(); rst = 1; cyc();
    rst = 0; idle(); cyc();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule